// File: doc/BRIEF.md
# UART Automatic Hardware Flow Control

This block sits beside a UART transmitter and receive FIFO. It handles the hardware handshake lines without software help. On the transmit side, it can hold back the transmitter while the remote end pulls its clear-to-send line inactive (high). The hold is applied or released only at a character boundary, so a frame already on the wire is never cut short. On the receive side, it raises a trigger interrupt when the FIFO fill reaches a programmed level. It can also drive the active-low request-to-send pin inactive before the FIFO overflows.

The RTS control uses hysteresis on a fixed ladder of trigger levels. The pin goes inactive at the rung above the programmed level. It becomes active again only after the FIFO has drained below the rung beneath the programmed level. Each automatic feature has its own enable. With auto-CTS off, transmission is always allowed. With auto-RTS off, the pin simply follows the modem-control RTS bit. All inputs and outputs are plain level control or status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `uart_autoflow`

## Requirements
- R1: After reset, `tx_allow` is 1, `rx_trig_irq` is 0, and the internal RTS stop state is clear, so `rts_n` equals `!mcr_rts`.
- R2: While `cts_auto_en` is 0, `tx_allow` is 1 in the same cycle, whatever the CTS pin or the boundary input does.
- R3: While `cts_auto_en` is 1, a cycle with `tx_boundary` high sets `tx_allow`, one clock later, to the inverse of `cts_n` in that cycle (1 = allowed).
- R4: While `cts_auto_en` is 1 and `tx_boundary` is low, `tx_allow` keeps its value even if `cts_n` changes.
- R5: The trigger ladder maps the 2-bit code `trig_sel` to these levels: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 14. `rx_trig_irq` is 1 one clock after a cycle in which `rx_level` is at or above the selected level. It is 0 one clock after a cycle in which `rx_level` is below it. This does not depend on the auto-RTS enable.
- R6: With `rts_auto_en` = 1 and `mcr_rts` = 1, the stop state is set one clock after `rx_level` reaches the next higher rung: 4, 8, 14 or 16 (full) for codes 0 to 3. While the stop state is set, `rts_n` is 1.
- R7: With `rts_auto_en` = 1, the stop state is cleared one clock after `rx_level` falls below the next lower rung: 1, 4 or 8 for codes 1 to 3. For code 0, it clears one clock after `rx_level` equals 0. Between the two thresholds, the stop state holds its value.
- R8: While `rts_auto_en` is 0, `rts_n` equals `!mcr_rts` in the same cycle. The stop state is cleared one clock later, so a later enable starts with RTS active.
- R9: With `rts_auto_en` = 1 and `mcr_rts` = 0, `rts_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_auto_en | input | 1 | Enables automatic CTS gating of transmission |
| rts_auto_en | input | 1 | Enables automatic RTS control |
| mcr_rts | input | 1 | Modem-control RTS request bit (1 = request active) |
| cts_n | input | 1 | Synchronised active-low CTS pin |
| tx_boundary | input | 1 | High while the transmitter is between characters |
| rx_level | input | 5 | Receive FIFO fill, 0 to 16 |
| trig_sel | input | 2 | Trigger ladder code |
| tx_allow | output | 1 | Transmitter may start a new character |
| rts_n | output | 1 | Active-low RTS pin |
| rx_trig_irq | output | 1 | Receive trigger interrupt request |

## Verification
A wrong CTS gate state shows up as a `tx_allow` value that differs from the CTS level at the most recent boundary. The error is visible one clock after that boundary and stays until the next one. A corrupt stop state shows on `rts_n` one clock after the level input enters the hysteresis band, and it persists as long as the level stays inside the band. For that reason, the tests move the level across each rung edge and also park it inside the band. A wrong ladder decode shows on `rx_trig_irq` one clock after the level reaches the edge of the selected rung.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int unsigned RUNGS = 4;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_L0 = 1;
  localparam int unsigned DEF_L1 = 4;
  localparam int unsigned DEF_L2 = 8;
  localparam int unsigned DEF_L3 = 14;

  typedef enum logic {
    GATE_OPEN = 1'b0,
    GATE_HELD = 1'b1
  } gate_state_e;
endpackage

// File: rtl/afc_ladder.sv
module afc_ladder
  import afc_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned L0 = DEF_L0,
  parameter int unsigned L1 = DEF_L1,
  parameter int unsigned L2 = DEF_L2,
  parameter int unsigned L3 = DEF_L3,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LVL_W-1:0] trig_lvl,
  output logic [LVL_W-1:0] hi_lvl,
  output logic [LVL_W-1:0] lo_lvl
);
  localparam int unsigned LAD [RUNGS] = '{L0, L1, L2, L3};

  logic [LVL_W-1:0] trig_tab [RUNGS];
  logic [LVL_W-1:0] hi_tab   [RUNGS];
  logic [LVL_W-1:0] lo_tab   [RUNGS];

  for (genvar i = 0; i < RUNGS; i++) begin : g_rung
    assign trig_tab[i] = LVL_W'(LAD[i]);
    if (i == RUNGS - 1) begin : g_top
      assign hi_tab[i] = LVL_W'(DEPTH);
    end else begin : g_mid_hi
      assign hi_tab[i] = LVL_W'(LAD[i+1]);
    end
    if (i == 0) begin : g_bot
      assign lo_tab[i] = '0;
    end else begin : g_mid_lo
      assign lo_tab[i] = LVL_W'(LAD[i-1]);
    end
  end

  assign trig_lvl = trig_tab[sel];
  assign hi_lvl   = hi_tab[sel];
  assign lo_lvl   = lo_tab[sel];
endmodule

// File: rtl/afc_cts_gate.sv
module afc_cts_gate
  import afc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cts_n,
  input  logic boundary,
  output logic allow
);
  gate_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_OPEN;
    end else if (boundary) begin
      state_q <= (en && cts_n) ? GATE_HELD : GATE_OPEN;
    end
  end

  assign allow = !en || (state_q == GATE_OPEN);
endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mcr_rts,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig_lvl,
  input  logic [LVL_W-1:0] hi_lvl,
  input  logic [LVL_W-1:0] lo_lvl,
  output logic             rts_n,
  output logic             irq
);
  logic stop_q;
  logic irq_q;
  logic reach_hi;
  logic drop_lo;

  assign reach_hi = (level >= hi_lvl);
  assign drop_lo  = (lo_lvl == '0) ? (level == '0) : (level < lo_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= (level >= trig_lvl);
      if (!en)           stop_q <= 1'b0;
      else if (reach_hi) stop_q <= 1'b1;
      else if (drop_lo)  stop_q <= 1'b0;
    end
  end

  assign rts_n = !mcr_rts || (en && stop_q);
  assign irq   = irq_q;
endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow
  import afc_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned L0 = DEF_L0,
  parameter int unsigned L1 = DEF_L1,
  parameter int unsigned L2 = DEF_L2,
  parameter int unsigned L3 = DEF_L3,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_auto_en,
  input  logic             rts_auto_en,
  input  logic             mcr_rts,
  input  logic             cts_n,
  input  logic             tx_boundary,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [SEL_W-1:0] trig_sel,
  output logic             tx_allow,
  output logic             rts_n,
  output logic             rx_trig_irq
);
  logic [LVL_W-1:0] trig_lvl, hi_lvl, lo_lvl;

  afc_ladder #(.DEPTH(DEPTH), .L0(L0), .L1(L1), .L2(L2), .L3(L3)) u_ladder (
    .sel(trig_sel), .trig_lvl(trig_lvl), .hi_lvl(hi_lvl), .lo_lvl(lo_lvl)
  );

  afc_cts_gate u_cts (
    .clk(clk), .rst_n(rst_n), .en(cts_auto_en), .cts_n(cts_n),
    .boundary(tx_boundary), .allow(tx_allow)
  );

  afc_rts_ctrl #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .en(rts_auto_en), .mcr_rts(mcr_rts),
    .level(rx_level), .trig_lvl(trig_lvl), .hi_lvl(hi_lvl), .lo_lvl(lo_lvl),
    .rts_n(rts_n), .irq(rx_trig_irq)
  );
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned L0 = 1,
  parameter int unsigned L1 = 4,
  parameter int unsigned L2 = 8,
  parameter int unsigned L3 = 14,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cts_auto_en,
  input logic             rts_auto_en,
  input logic             mcr_rts,
  input logic             cts_n,
  input logic             tx_boundary,
  input logic [LVL_W-1:0] rx_level,
  input logic [1:0]       trig_sel,
  input logic             tx_allow,
  input logic             rts_n,
  input logic             rx_trig_irq
);
  function automatic int unsigned rung(input logic [1:0] s);
    case (s)
      2'd0: return L0;
      2'd1: return L1;
      2'd2: return L2;
      default: return L3;
    endcase
  endfunction

  function automatic int unsigned upper(input logic [1:0] s);
    return (s == 2'd3) ? DEPTH : rung(s + 2'd1);
  endfunction

  logic at_trig, at_hi;
  assign at_trig = (int'(rx_level) >= int'(rung(trig_sel)));
  assign at_hi   = (int'(rx_level) >= int'(upper(trig_sel)));

  assert_cts_off_allows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_auto_en |-> tx_allow);

  assert_boundary_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_auto_en && tx_boundary) |=> (!cts_auto_en || tx_allow == !$past(cts_n)));

  assert_hold_mid_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_auto_en && !tx_boundary) |=> (!cts_auto_en || $stable(tx_allow)));

  assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    at_trig |=> rx_trig_irq);

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !at_trig |=> !rx_trig_irq);

  assert_rts_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_auto_en && at_hi) |=> (!rts_auto_en || rts_n));

  assert_rts_manual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_auto_en |-> (rts_n == !mcr_rts));

  assert_rts_mcr_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_rts |-> rts_n);
endmodule

bind uart_autoflow afc_checker #(.DEPTH(DEPTH), .L0(L0), .L1(L1), .L2(L2), .L3(L3)) u_chk (
  .clk(clk), .rst_n(rst_n), .cts_auto_en(cts_auto_en), .rts_auto_en(rts_auto_en),
  .mcr_rts(mcr_rts), .cts_n(cts_n), .tx_boundary(tx_boundary), .rx_level(rx_level),
  .trig_sel(trig_sel), .tx_allow(tx_allow), .rts_n(rts_n), .rx_trig_irq(rx_trig_irq)
);

// File: tb/sim_uart_autoflow.sv
`timescale 1ns/1ps
module sim_uart_autoflow;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_auto_en = 1'b0, rts_auto_en = 1'b0, mcr_rts = 1'b1;
  logic cts_n = 1'b0, tx_boundary = 1'b0;
  logic [4:0] rx_level = '0;
  logic [1:0] trig_sel = '0;
  logic tx_allow, rts_n, rx_trig_irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  uart_autoflow u0 (
    .clk(clk), .rst_n(rst_n), .cts_auto_en(cts_auto_en), .rts_auto_en(rts_auto_en),
    .mcr_rts(mcr_rts), .cts_n(cts_n), .tx_boundary(tx_boundary), .rx_level(rx_level),
    .trig_sel(trig_sel), .tx_allow(tx_allow), .rts_n(rts_n), .rx_trig_irq(rx_trig_irq)
  );

  // Ladder per R5, upper rung per R6, lower rung per R7
  function automatic int trig_of(input int c);
    case (c) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction
  function automatic int hi_of(input int c);
    case (c) 0: return 4; 1: return 8; 2: return 14; default: return 16; endcase
  endfunction
  function automatic int lo_of(input int c);
    case (c) 0: return 0; 1: return 1; 2: return 4; default: return 8; endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 tx_allow", tx_allow, 1'b1);
    chk("R1 irq", rx_trig_irq, 1'b0);
    chk("R1 rts_n", rts_n, 1'b0);
  endtask

  task automatic t_cts_gate;
    cts_auto_en = 1'b1; cts_n = 1'b1; tx_boundary = 1'b0;
    step();
    chk("R4 mid-char CTS high ignored", tx_allow, 1'b1);
    tx_boundary = 1'b1;
    step();
    chk("R3 boundary with CTS high", tx_allow, 1'b0);
    tx_boundary = 1'b0; cts_n = 1'b0;
    step(); step();
    chk("R4 held until boundary", tx_allow, 1'b0);
    tx_boundary = 1'b1;
    step();
    chk("R3 boundary with CTS low", tx_allow, 1'b1);
    cts_n = 1'b1;
    step();
    chk("R3 held at second boundary", tx_allow, 1'b0);
    tx_boundary = 1'b0;
    cts_auto_en = 1'b0;
    #1;
    chk("R2 disable releases at once", tx_allow, 1'b1);
    tx_boundary = 1'b1;
    step();
    chk("R2 boundary ignored when off", tx_allow, 1'b1);
    tx_boundary = 1'b0; cts_n = 1'b0;
  endtask

  task automatic t_irq_ladder;
    for (int c = 0; c < 4; c++) begin
      trig_sel = 2'(c);
      rx_level = 5'(trig_of(c) - 1);
      step();
      chk("R5 below trigger", rx_trig_irq, 1'b0);
      rx_level = 5'(trig_of(c));
      step();
      chk("R5 at trigger", rx_trig_irq, 1'b1);
      rx_level = 5'(trig_of(c) - 1);
      step();
      chk("R5 cleared below", rx_trig_irq, 1'b0);
    end
    rx_level = '0;
  endtask

  task automatic t_rts_hyst;
    rts_auto_en = 1'b1; mcr_rts = 1'b1;
    for (int c = 0; c < 4; c++) begin
      trig_sel = 2'(c);
      rx_level = '0;
      step();
      rx_level = 5'(hi_of(c) - 1);
      step();
      chk("R6 below upper rung", rts_n, 1'b0);
      rx_level = 5'(hi_of(c));
      step();
      chk("R6 at upper rung", rts_n, 1'b1);
      rx_level = 5'((lo_of(c) == 0) ? 1 : lo_of(c));
      step();
      chk("R7 inside band holds", rts_n, 1'b1);
      rx_level = 5'((lo_of(c) == 0) ? 0 : lo_of(c) - 1);
      step();
      chk("R7 released below lower rung", rts_n, 1'b0);
    end
    rx_level = '0;
  endtask

  task automatic t_rts_manual;
    trig_sel = 2'd3; rts_auto_en = 1'b1; mcr_rts = 1'b1; rx_level = 5'd16;
    step();
    chk("R6 full FIFO stops", rts_n, 1'b1);
    mcr_rts = 1'b0; rx_level = '0;
    step();
    chk("R9 mcr off with auto on", rts_n, 1'b1);
    mcr_rts = 1'b1; rx_level = 5'd16;
    step();
    rts_auto_en = 1'b0;
    #1;
    chk("R8 disable follows mcr", rts_n, 1'b0);
    mcr_rts = 1'b0;
    #1;
    chk("R8 mcr low drives pin high", rts_n, 1'b1);
    mcr_rts = 1'b1; rx_level = 5'd10;
    step();
    rts_auto_en = 1'b1;
    step();
    chk("R8 stop state cleared while off", rts_n, 1'b0);
    rts_auto_en = 1'b0; rx_level = '0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_cts_gate();
    t_irq_ladder();
    t_rts_hyst();
    t_rts_manual();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule